// File: doc/BRIEF.md
# AXI Transaction Latency Profiler

This block is a passive observer placed beside one AXI master port. It watches the handshake signals of the read address, read data, write address and write response channels. For each transaction it works out how many clock cycles passed between its start and its completion. It never drives the bus.

Every transaction is measured from two starting points. The first is the cycle in which its address valid was first seen. The second is the cycle in which its address handshake completed. Each of the two measures also has a second form that leaves out any time during which the previous transaction in the same direction was still in flight. This gives four measures for reads and four for writes. For each measure the block keeps a running count, a saturating sum, a minimum and a maximum. Software reads them one at a time through an indexed read port. Completions are taken to arrive in the same order as the addresses.

Top module: `axi_lat_profiler`

## Requirements
- R1: After reset or a `clear` pulse, every count and sum reads 0, every minimum reads all ones, every maximum reads 0, and both overflow flags read 0.
- R2: Valid-based latency runs from the first cycle in which the address valid is high to the completion cycle, counted as the difference between the two cycle numbers.
- R3: Handshake-based latency runs from the cycle in which address valid and ready are both high to the completion cycle.
- R4: The overlap-excluding form of each measure starts at the later of the transaction's own start and the completion cycle of the previous transaction in the same direction. The including form always starts at the transaction's own start.
- R5: A write completes on the write-response handshake. Write measures are kept apart from read measures, and a write never changes a read statistic.
- R6: Each completion adds 1 to the count, adds its latency to the sum, lowers the minimum if the latency is smaller, and raises the maximum if the latency is larger.
- R7: A sum that would pass 2^SUM_W-1 stays at 2^SUM_W-1.
- R8: A completion seen while `enable` is low leaves every statistic unchanged.
- R9: Up to DEPTH transactions may be pending in each direction. An address handshake that finds DEPTH pending sets that direction's overflow flag, and the flag stays set until `clear`.
- R10: `reg_data` returns, one clock after `reg_idx` is applied, the field selected by `reg_idx`. Bits [4:3] pick the statistic (0 count, 1 sum, 2 minimum, 3 maximum). Bit [2] picks the direction (0 read, 1 write). Bits [1:0] pick the measure (0 valid-including, 1 handshake-including, 2 valid-excluding, 3 handshake-excluding).
- R11: A read completes only on a data beat where valid, ready and last are all high. A beat without last, or a last beat that is not accepted, completes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Statistics update only while high |
| clear | input | 1 | Resets statistics and overflow flags |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_last | input | 1 | Read data last beat |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| reg_idx | input | 5 | Statistic selector |
| reg_data | output | RD_W | Selected statistic, registered |
| rd_ovf | output | 1 | Read pending-queue overflow, sticky |
| wr_ovf | output | 1 | Write pending-queue overflow, sticky |

## Verification
A wrong start timestamp or a queue pointer that is out of step shows up as a sum or extreme value that is off. This is visible on `reg_data` two clocks after the completion that carries the error: one clock for the statistic update and one for the registered read. A wrong previous-completion register changes only the overlap-excluding measures. For that reason the bench uses overlapping reads whose including and excluding results differ. An overflow or clear fault shows on the flag pins in the very next cycle.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_SUM   = 2'd1,
    ST_MIN   = 2'd2,
    ST_MAX   = 2'd3
  } stat_e;

  localparam int NUM_MEAS = 4;
endpackage

// File: rtl/lat_fifo.sv
module lat_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  assign empty = (fill == '0);
  assign full  = (fill == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/lat_acc.sv
module lat_acc #(
  parameter int TS_W  = 32,
  parameter int SUM_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             upd,
  input  logic [TS_W-1:0]  lat,
  output logic [TS_W-1:0]  cnt,
  output logic [SUM_W-1:0] sum,
  output logic [TS_W-1:0]  mn,
  output logic [TS_W-1:0]  mx
);
  localparam int ACC_W = ((SUM_W > TS_W) ? SUM_W : TS_W) + 1;
  localparam logic [ACC_W-1:0] SUM_CAP = ACC_W'({SUM_W{1'b1}});

  logic [ACC_W-1:0] tot;
  assign tot = ACC_W'(sum) + ACC_W'(lat);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      sum <= '0;
      mn  <= '1;
      mx  <= '0;
    end else if (upd) begin
      cnt <= cnt + 1'b1;
      sum <= (tot > SUM_CAP) ? {SUM_W{1'b1}} : tot[SUM_W-1:0];
      if (lat < mn) mn <= lat;
      if (lat > mx) mx <= lat;
    end
  end
endmodule

// File: rtl/lat_dir.sv
module lat_dir #(
  parameter int TS_W  = 32,
  parameter int SUM_W = 48,
  parameter int DEPTH = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              clear,
  input  logic                              enable,
  input  logic [TS_W-1:0]                   now,
  input  logic                              a_valid,
  input  logic                              a_ready,
  input  logic                              e_fire,
  output logic                              ovf,
  output logic [lat_pkg::NUM_MEAS-1:0][TS_W-1:0]  cnt_o,
  output logic [lat_pkg::NUM_MEAS-1:0][SUM_W-1:0] sum_o,
  output logic [lat_pkg::NUM_MEAS-1:0][TS_W-1:0]  min_o,
  output logic [lat_pkg::NUM_MEAS-1:0][TS_W-1:0]  max_o
);
  localparam int ENT_W = 2 * TS_W;

  logic            a_seen;
  logic [TS_W-1:0] vts_hold, vstart;
  logic            a_fire, push, pop, q_empty, q_full;
  logic [ENT_W-1:0] q_out;
  logic [TS_W-1:0] head_v, head_h;
  logic [TS_W-1:0] prev_end;
  logic            prev_ok;
  logic [TS_W-1:0] since_prev;
  logic [lat_pkg::NUM_MEAS-1:0][TS_W-1:0] lats;

  assign a_fire = a_valid && a_ready;
  assign vstart = a_seen ? vts_hold : now;
  assign push   = a_fire && !q_full;
  assign pop    = e_fire && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_seen   <= 1'b0;
      vts_hold <= '0;
    end else if (a_fire) begin
      a_seen <= 1'b0;
    end else if (a_valid && !a_seen) begin
      a_seen   <= 1'b1;
      vts_hold <= now;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) ovf <= 1'b0;
    else if (a_fire && q_full) ovf <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_end <= '0;
      prev_ok  <= 1'b0;
    end else if (pop) begin
      prev_end <= now;
      prev_ok  <= 1'b1;
    end
  end

  lat_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(push), .din({vstart, now}),
    .pop(pop), .dout(q_out), .empty(q_empty), .full(q_full)
  );

  assign head_v     = q_out[ENT_W-1:TS_W];
  assign head_h     = q_out[TS_W-1:0];
  assign since_prev = now - prev_end;

  always_comb begin
    lats[0] = now - head_v;
    lats[1] = now - head_h;
    lats[2] = (prev_ok && since_prev < lats[0]) ? since_prev : lats[0];
    lats[3] = (prev_ok && since_prev < lats[1]) ? since_prev : lats[1];
  end

  for (genvar g = 0; g < lat_pkg::NUM_MEAS; g++) begin : g_acc
    lat_acc #(.TS_W(TS_W), .SUM_W(SUM_W)) u_acc (
      .clk(clk), .rst(rst), .clear(clear), .upd(pop && enable),
      .lat(lats[g]), .cnt(cnt_o[g]), .sum(sum_o[g]),
      .mn(min_o[g]), .mx(max_o[g])
    );
  end
endmodule

// File: rtl/axi_lat_profiler.sv
module axi_lat_profiler #(
  parameter int TS_W  = 32,
  parameter int SUM_W = 48,
  parameter int DEPTH = 8,
  parameter int RD_W  = (SUM_W > TS_W) ? SUM_W : TS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            clear,
  input  logic            ar_valid,
  input  logic            ar_ready,
  input  logic            r_valid,
  input  logic            r_ready,
  input  logic            r_last,
  input  logic            aw_valid,
  input  logic            aw_ready,
  input  logic            b_valid,
  input  logic            b_ready,
  input  logic [4:0]      reg_idx,
  output logic [RD_W-1:0] reg_data,
  output logic            rd_ovf,
  output logic            wr_ovf
);
  import lat_pkg::*;

  logic [TS_W-1:0] now;
  logic [1:0][NUM_MEAS-1:0][TS_W-1:0]  cnt_a, min_a, max_a;
  logic [1:0][NUM_MEAS-1:0][SUM_W-1:0] sum_a;
  logic [1:0] ovf_a;
  logic [1:0] av, ar, ef;
  logic [RD_W-1:0] sel;
  stat_e st;
  logic  dsel;
  logic [1:0] msel;

  always_ff @(posedge clk) begin
    if (rst) now <= '0;
    else     now <= now + 1'b1;
  end

  assign av = {aw_valid, ar_valid};
  assign ar = {aw_ready, ar_ready};
  assign ef = {b_valid && b_ready, r_valid && r_ready && r_last};

  for (genvar d = 0; d < 2; d++) begin : g_dir
    lat_dir #(.TS_W(TS_W), .SUM_W(SUM_W), .DEPTH(DEPTH)) u_dir (
      .clk(clk), .rst(rst), .clear(clear), .enable(enable), .now(now),
      .a_valid(av[d]), .a_ready(ar[d]), .e_fire(ef[d]), .ovf(ovf_a[d]),
      .cnt_o(cnt_a[d]), .sum_o(sum_a[d]), .min_o(min_a[d]), .max_o(max_a[d])
    );
  end

  assign rd_ovf = ovf_a[0];
  assign wr_ovf = ovf_a[1];

  assign st   = stat_e'(reg_idx[4:3]);
  assign dsel = reg_idx[2];
  assign msel = reg_idx[1:0];

  always_comb begin
    case (st)
      ST_COUNT: sel = RD_W'(cnt_a[dsel][msel]);
      ST_SUM:   sel = RD_W'(sum_a[dsel][msel]);
      ST_MIN:   sel = RD_W'(min_a[dsel][msel]);
      default:  sel = RD_W'(max_a[dsel][msel]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_data <= '0;
    else     reg_data <= sel;
  end
endmodule

// File: rtl/lat_prof_checker.sv
module lat_prof_checker #(
  parameter int RD_W = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            clear,
  input logic            ar_valid,
  input logic            ar_ready,
  input logic            r_valid,
  input logic            r_ready,
  input logic            r_last,
  input logic            aw_valid,
  input logic            aw_ready,
  input logic            b_valid,
  input logic            b_ready,
  input logic [4:0]      reg_idx,
  input logic [RD_W-1:0] reg_data,
  input logic            rd_ovf,
  input logic            wr_ovf
);
  logic quiet;
  assign quiet = !rst && !clear && !(r_valid && r_ready && r_last) && !(b_valid && b_ready);

  AST_RD_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rd_ovf && !clear) |=> rd_ovf); // R9
  AST_WR_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wr_ovf && !clear) |=> wr_ovf); // R9
  AST_RD_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_ovf) |-> $past(ar_valid && ar_ready)); // R9
  AST_WR_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_ovf) |-> $past(aw_valid && aw_ready)); // R9
  AST_CLEAR_OVF: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!rd_ovf && !wr_ovf)); // R1
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(quiet, 2) && !$past(rst, 3) && ($past(reg_idx, 1) == $past(reg_idx, 2)))
      |-> $stable(reg_data)); // R10
endmodule

bind axi_lat_profiler lat_prof_checker #(.RD_W(RD_W)) u_chk (
  .clk(clk), .rst(rst), .clear(clear),
  .ar_valid(ar_valid), .ar_ready(ar_ready),
  .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last),
  .aw_valid(aw_valid), .aw_ready(aw_ready),
  .b_valid(b_valid), .b_ready(b_ready),
  .reg_idx(reg_idx), .reg_data(reg_data),
  .rd_ovf(rd_ovf), .wr_ovf(wr_ovf)
);

// File: tb/axi_lat_profiler_tb_top.sv
`timescale 1ns/1ps
module axi_lat_profiler_tb_top;
  localparam int TS_W  = 32;
  localparam int SUM_W = 12;
  localparam int RD_W  = 32;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst, enable, clear;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic aw_valid, aw_ready, b_valid, b_ready;
  logic [4:0] reg_idx;
  logic [RD_W-1:0] reg_data;
  logic rd_ovf, wr_ovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  axi_lat_profiler #(.TS_W(TS_W), .SUM_W(SUM_W), .DEPTH(8)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .clear(clear),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .r_valid(r_valid),
    .r_ready(r_ready), .r_last(r_last), .aw_valid(aw_valid),
    .aw_ready(aw_ready), .b_valid(b_valid), .b_ready(b_ready),
    .reg_idx(reg_idx), .reg_data(reg_data), .rd_ovf(rd_ovf), .wr_ovf(wr_ovf)
  );

  function automatic logic [4:0] ix(int st, int d, int m);
    return {st[1:0], d[0], m[1:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%h) expected %0d (0x%h)", req, act, act, exp, exp);
    end
  endtask

  task automatic rd_stat(string req, logic [4:0] idx, logic [31:0] exp);
    reg_idx = idx;
    @(negedge clk);
    chk(req, reg_data, exp);
  endtask

  task automatic idle_bus();
    ar_valid = 0; ar_ready = 0; r_valid = 0; r_ready = 0; r_last = 0;
    aw_valid = 0; aw_ready = 0; b_valid = 0; b_ready = 0;
  endtask

  task automatic pulse_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic read_txn(int wv, int lat);
    for (int c = 0; c <= lat; c++) begin
      ar_valid = (c <= wv); ar_ready = (c == wv);
      r_valid = (c == lat); r_last = (c == lat); r_ready = 1'b1;
      @(negedge clk);
    end
    idle_bus();
  endtask

  task automatic write_txn(int wv, int lat);
    for (int c = 0; c <= lat; c++) begin
      aw_valid = (c <= wv); aw_ready = (c == wv);
      b_valid = (c == lat); b_ready = 1'b1;
      @(negedge clk);
    end
    idle_bus();
  endtask

  task automatic t_reset();
    rd_stat("R1 count", ix(0,0,0), 0);
    rd_stat("R1 sum", ix(1,1,3), 0);
    rd_stat("R1 min", ix(2,0,2), ONES);
    rd_stat("R1 max", ix(3,1,1), 0);
    chk("R1 rd_ovf", {31'd0, rd_ovf}, 0);
    chk("R1 wr_ovf", {31'd0, wr_ovf}, 0);
  endtask

  task automatic t_single_read();
    pulse_clear();
    read_txn(3, 10);
    rd_stat("R6 R10 count", ix(0,0,0), 1);
    rd_stat("R2 valid sum", ix(1,0,0), 10);
    rd_stat("R3 hs sum", ix(1,0,1), 7);
    rd_stat("R2 valid min", ix(2,0,0), 10);
    rd_stat("R3 hs max", ix(3,0,1), 7);
  endtask

  task automatic t_overlap();
    pulse_clear();
    for (int c = 0; c <= 11; c++) begin
      ar_valid = (c == 0) || (c == 2) || (c == 3);
      ar_ready = (c == 0) || (c == 3);
      r_valid  = (c == 4) || (c == 6) || (c == 8) || (c == 11);
      r_ready  = (c != 8);
      r_last   = (c != 4);
      @(negedge clk);
    end
    idle_bus();
    rd_stat("R11 count", ix(0,0,0), 2);
    rd_stat("R6 valid-incl sum", ix(1,0,0), 15);
    rd_stat("R6 hs-incl sum", ix(1,0,1), 14);
    rd_stat("R4 valid-excl sum", ix(1,0,2), 11);
    rd_stat("R4 hs-excl sum", ix(1,0,3), 11);
    rd_stat("R6 valid-incl max", ix(3,0,0), 9);
    rd_stat("R6 hs-incl max", ix(3,0,1), 8);
    rd_stat("R4 valid-excl min", ix(2,0,2), 5);
    rd_stat("R6 valid-incl min", ix(2,0,0), 6);
    rd_stat("R4 hs-excl max", ix(3,0,3), 6);
  endtask

  task automatic t_write();
    write_txn(2, 7);
    rd_stat("R5 wr count", ix(0,1,0), 1);
    rd_stat("R5 wr valid sum", ix(1,1,0), 7);
    rd_stat("R5 wr hs sum", ix(1,1,1), 5);
    rd_stat("R5 rd count unchanged", ix(0,0,0), 2);
    rd_stat("R5 rd sum unchanged", ix(1,0,0), 15);
  endtask

  task automatic t_enable();
    pulse_clear();
    enable = 1'b0;
    read_txn(1, 4);
    rd_stat("R8 count held", ix(0,0,0), 0);
    rd_stat("R8 min held", ix(2,0,1), ONES);
    enable = 1'b1;
    read_txn(1, 4);
    rd_stat("R8 count after enable", ix(0,0,0), 1);
    rd_stat("R8 sum after enable", ix(1,0,0), 4);
  endtask

  task automatic t_overflow();
    pulse_clear();
    for (int i = 0; i < 8; i++) begin
      ar_valid = 1; ar_ready = 1;
      @(negedge clk);
    end
    chk("R9 no ovf at depth", {31'd0, rd_ovf}, 0);
    @(negedge clk);
    chk("R9 ovf on extra", {31'd0, rd_ovf}, 1);
    chk("R9 wr_ovf untouched", {31'd0, wr_ovf}, 0);
    idle_bus();
    for (int i = 0; i < 9; i++) begin
      r_valid = 1; r_ready = 1; r_last = 1;
      @(negedge clk);
    end
    idle_bus();
    chk("R9 ovf sticky", {31'd0, rd_ovf}, 1);
    rd_stat("R9 count of stored", ix(0,0,0), 8);
    pulse_clear();
    chk("R1 ovf cleared", {31'd0, rd_ovf}, 0);
    rd_stat("R1 count cleared", ix(0,0,0), 0);
    rd_stat("R1 min reset", ix(2,0,3), ONES);
    rd_stat("R1 max reset", ix(3,0,0), 0);
  endtask

  task automatic t_saturate();
    pulse_clear();
    read_txn(0, 5000);
    rd_stat("R7 sum saturated", ix(1,0,0), 32'd4095);
    rd_stat("R7 max exact", ix(3,0,0), 32'd5000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; enable = 1; clear = 0; reg_idx = '0;
    idle_bus();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_single_read();
    t_overlap();
    t_write();
    t_enable();
    t_overflow();
    t_saturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule